// File: doc/BRIEF.md
# Pin Debounce Filter

This block cleans up to 32 general-purpose input pins before the rest of the I/O logic sees them. Each pin can be passed through a filter that runs on a separate, slow debounce clock of about 32.768 kHz, so one debounce period is roughly 31 µs. A pin's filtered level changes only once the pin has shown its new level on T+1 consecutive debounce samples. T is one 8-bit hold time that every pin shares. A short spike is dropped. A sampled level that falls back to the current filtered level restarts the count.

Each pin carries an enable bit. The filter applies only when that bit is set and the pin is configured as an input. Every other pin takes a bypass path: a two-flop synchronizer on the interface clock followed by the output register. Configuration crosses into the debounce domain through synchronizers and is treated as quasi-static. Software must hold it steady for a few debounce periods before it relies on the result. Filtered levels return to the interface domain through a two-flop synchronizer per bit.

One asynchronous reset drives both domains. Each domain releases it through its own synchronizer. A reset-done flag on the interface side rises only after both domains have left reset.

Top module: `pin_deglitch_filter`

## Requirements
- R1: While `rst_n` is low, `pin_out` is all zeros and `reset_done` is 0.
- R2: After `rst_n` rises, `reset_done` stays 0 until the debounce-domain reset has also been released, then goes to 1. It never reads 1 while either domain is still in reset.
- R3: A filtered pin accepts a new level only after T+1 consecutive debounce samples of that level. A pulse lasting L debounce periods reaches `pin_out` exactly when L >= T+1, and a rejected pulse produces no glitch at `pin_out`.
- R4: For a filtered pin, a level change is absent from `pin_out` T+2 debounce periods after the pin edge and present one debounce period later (two debounce sync stages, T+1 samples, three interface flops).
- R5: On a filtered pin, any sample equal to the current filtered level restarts the count. Two runs of T samples separated by one opposite sample are rejected.
- R6: A pin with its enable bit 0 bypasses the filter. A change at the pin appears on `pin_out` on the third interface clock edge after it, so a pulse shorter than one debounce period still passes.
- R7: A pin configured as an output (`dir_in` bit 0) takes the bypass path even when its enable bit is 1.
- R8: All pins use the same hold time T, but each pin counts on its own. Pulses of different lengths on different pins are accepted or rejected per pin, and accepted pins return low independently.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| if_clk | input | 1 | Interface clock; drives the output register, bypass path and reset-done flag |
| db_clk | input | 1 | Slow debounce clock that runs the per-pin counters |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| pin_in | input | PINS | Raw, asynchronous pin levels |
| filt_en | input | PINS | Per-pin filter enable (1 = filter) |
| dir_in | input | PINS | Per-pin direction (1 = input, 0 = output) |
| hold_time | input | TIME_W | Shared hold time T; a new level must persist T+1 debounce periods |
| pin_out | output | PINS | Filtered or bypassed pin levels, interface domain |
| reset_done | output | 1 | 1 once both clock domains have completed reset |

## Verification
The bench sweeps T from 0 to 8. In each run, eight pins carry pulses of 1 to 8 debounce periods, and any pin that ever goes high is recorded. A filter with an off-by-one in the count would accept the T-period pulse or reject the T+1-period one. The latency probe samples one debounce period on either side of the expected update, which catches a missing or extra synchronizer stage. The interrupted-hold case catches a counter that pauses instead of restarting. The bypass pulses, shorter than one debounce period, would vanish if the enable or direction gating were inverted. An early `reset_done` shows up in the window before the debounce reset is released.

// File: rtl/dg_pkg.sv
`timescale 1ns/1ps
package dg_pkg;

  // Synchronizer depth used on every crossing of this block.
  localparam int unsigned SYNC_DEPTH = 2;

  // True once a pin has shown a differing level on enough samples.
  function automatic logic span_reached(input int unsigned cnt, input int unsigned lim);
    return cnt >= lim;
  endfunction

  // Next counter value while a differing level keeps being sampled.
  function automatic int unsigned bump(input int unsigned cnt);
    return cnt + 1;
  endfunction

endpackage

// File: rtl/dg_sync.sv
`timescale 1ns/1ps
module dg_sync #(
  parameter int W      = 1,
  parameter int STAGES = dg_pkg::SYNC_DEPTH
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dg_rst_sync.sv
`timescale 1ns/1ps
module dg_rst_sync #(
  parameter int STAGES = dg_pkg::SYNC_DEPTH
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_out
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain <= '0;
    else         chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = chain[STAGES-1];
endmodule

// File: rtl/dg_pin_filter.sv
`timescale 1ns/1ps
module dg_pin_filter #(
  parameter int TIME_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              samp,
  input  logic [TIME_W-1:0] limit,
  output logic              level,
  output logic              flip,
  output logic [TIME_W-1:0] count
);
  import dg_pkg::*;

  logic differ;
  logic reached;

  assign differ  = samp ^ level;
  assign reached = span_reached(32'(count), 32'(limit));
  // Event: the filtered level takes the sampled value at the next edge.
  assign flip    = en & differ & reached;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= 1'b0;
      count <= '0;
    end else if (!en) begin
      level <= samp;
      count <= '0;
    end else if (!differ) begin
      count <= '0;
    end else if (reached) begin
      level <= samp;
      count <= '0;
    end else begin
      count <= TIME_W'(bump(32'(count)));
    end
  end
endmodule

// File: rtl/pin_deglitch_filter.sv
`timescale 1ns/1ps
module pin_deglitch_filter #(
  parameter int PINS   = 32,
  parameter int TIME_W = 8
) (
  input  logic              if_clk,
  input  logic              db_clk,
  input  logic              rst_n,
  input  logic [PINS-1:0]   pin_in,
  input  logic [PINS-1:0]   filt_en,
  input  logic [PINS-1:0]   dir_in,
  input  logic [TIME_W-1:0] hold_time,
  output logic [PINS-1:0]   pin_out,
  output logic              reset_done
);
  localparam int CFG_W = PINS + TIME_W;

  // Per-domain reset release
  logic if_rst_n;
  logic db_rst_n;

  dg_rst_sync u_if_rst (.clk(if_clk), .arst_n(rst_n), .rst_n_out(if_rst_n));
  dg_rst_sync u_db_rst (.clk(db_clk), .arst_n(rst_n), .rst_n_out(db_rst_n));

  // Pins that use the filter (interface domain)
  logic [PINS-1:0] en_if;
  assign en_if = filt_en & dir_in;

  // Configuration into the debounce domain (quasi-static)
  logic [CFG_W-1:0]  cfg_db;
  logic [PINS-1:0]   en_db;
  logic [TIME_W-1:0] t_db;

  dg_sync #(.W(CFG_W)) u_cfg_x (
    .clk(db_clk), .rst_n(db_rst_n), .d({en_if, hold_time}), .q(cfg_db)
  );
  assign en_db = cfg_db[CFG_W-1:TIME_W];
  assign t_db  = cfg_db[TIME_W-1:0];

  // Pin sampling on the debounce clock
  logic [PINS-1:0] samp_db;
  dg_sync #(.W(PINS)) u_pin_db (
    .clk(db_clk), .rst_n(db_rst_n), .d(pin_in), .q(samp_db)
  );

  // Per-pin stability counters
  logic [PINS-1:0]        lvl_db;
  logic [PINS-1:0]        flip_db;
  logic [PINS*TIME_W-1:0] cnt_flat;

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    logic [TIME_W-1:0] cnt_i;
    dg_pin_filter #(.TIME_W(TIME_W)) u_flt (
      .clk   (db_clk),
      .rst_n (db_rst_n),
      .en    (en_db[i]),
      .samp  (samp_db[i]),
      .limit (t_db),
      .level (lvl_db[i]),
      .flip  (flip_db[i]),
      .count (cnt_i)
    );
    assign cnt_flat[i*TIME_W +: TIME_W] = cnt_i;
  end

  // Filtered levels back to the interface domain
  logic [PINS-1:0] lvl_if;
  dg_sync #(.W(PINS)) u_lvl_x (
    .clk(if_clk), .rst_n(if_rst_n), .d(lvl_db), .q(lvl_if)
  );

  // Bypass path on the interface clock
  logic [PINS-1:0] raw_if;
  dg_sync #(.W(PINS)) u_raw_if (
    .clk(if_clk), .rst_n(if_rst_n), .d(pin_in), .q(raw_if)
  );

  always_ff @(posedge if_clk or negedge if_rst_n) begin
    if (!if_rst_n) pin_out <= '0;
    else           pin_out <= (en_if & lvl_if) | (~en_if & raw_if);
  end

  // Reset-done: debounce-domain release seen from the interface side
  logic db_up_if;
  logic done_q;

  dg_sync #(.W(1)) u_done_x (
    .clk(if_clk), .rst_n(if_rst_n), .d(db_rst_n), .q(db_up_if)
  );

  always_ff @(posedge if_clk or negedge if_rst_n) begin
    if (!if_rst_n) done_q <= 1'b0;
    else           done_q <= db_up_if;
  end

  assign reset_done = done_q;
endmodule

// File: rtl/pin_deglitch_filter_chk.sv
`timescale 1ns/1ps
module pin_deglitch_filter_chk #(
  parameter int PINS   = 32,
  parameter int TIME_W = 8
) (
  input logic                     if_clk,
  input logic                     db_clk,
  input logic                     rst_n,
  input logic                     if_rst_n,
  input logic                     db_rst_n,
  input logic [PINS-1:0]          pin_in,
  input logic [PINS-1:0]          en_if,
  input logic [PINS-1:0]          en_db,
  input logic [TIME_W-1:0]        t_db,
  input logic [PINS-1:0]          samp_db,
  input logic [PINS-1:0]          lvl_db,
  input logic [PINS-1:0]          flip_db,
  input logic [PINS*TIME_W-1:0]   cnt_flat,
  input logic [PINS-1:0]          pin_out,
  input logic                     reset_done
);
  // Interface cycles since the interface reset released (saturating)
  logic [2:0] age;
  always_ff @(posedge if_clk or negedge if_rst_n) begin
    if (!if_rst_n)      age <= '0;
    else if (age != 3'd7) age <= age + 3'd1;
  end
  logic age_ok;
  assign age_ok = (age >= 3'd4);

  // R2
  done_after_both_chk: assert property (@(posedge if_clk) disable iff (!rst_n)
    reset_done |-> db_rst_n);

  for (genvar i = 0; i < PINS; i++) begin : g_chk
    // R6
    bypass_follow_chk: assert property (@(posedge if_clk) disable iff (!if_rst_n)
      (age_ok && !$past(en_if[i])) |-> (pin_out[i] == $past(pin_in[i], 3)));

    // R4
    filtered_follow_chk: assert property (@(posedge if_clk) disable iff (!if_rst_n)
      (age_ok && $past(en_if[i])) |-> (pin_out[i] == $past(lvl_db[i], 3)));

    // R3
    level_moves_to_sample_chk: assert property (@(posedge db_clk) disable iff (!db_rst_n)
      ($past(en_db[i]) && (lvl_db[i] != $past(lvl_db[i]))) |-> (lvl_db[i] == $past(samp_db[i])));

    // R3
    flip_event_chk: assert property (@(posedge db_clk) disable iff (!db_rst_n)
      flip_db[i] |=> (lvl_db[i] != $past(lvl_db[i])));

    // R5
    count_bound_chk: assert property (@(posedge db_clk) disable iff (!db_rst_n)
      ($stable(t_db) && $past(en_db[i])) |-> (cnt_flat[i*TIME_W +: TIME_W] <= t_db));
  end
endmodule

bind pin_deglitch_filter pin_deglitch_filter_chk #(.PINS(PINS), .TIME_W(TIME_W)) u_chk (
  .if_clk     (if_clk),
  .db_clk     (db_clk),
  .rst_n      (rst_n),
  .if_rst_n   (if_rst_n),
  .db_rst_n   (db_rst_n),
  .pin_in     (pin_in),
  .en_if      (en_if),
  .en_db      (en_db),
  .t_db       (t_db),
  .samp_db    (samp_db),
  .lvl_db     (lvl_db),
  .flip_db    (flip_db),
  .cnt_flat   (cnt_flat),
  .pin_out    (pin_out),
  .reset_done (reset_done)
);

// File: tb/pin_deglitch_filter_test.sv
`timescale 1ns/1ps
module pin_deglitch_filter_test;
  localparam int PINS   = 8;
  localparam int TIME_W = 8;

  logic              if_clk = 1'b0;
  logic              db_clk = 1'b0;
  logic              rst_n;
  logic [PINS-1:0]   pin_in;
  logic [PINS-1:0]   filt_en;
  logic [PINS-1:0]   dir_in;
  logic [TIME_W-1:0] hold_time;
  logic [PINS-1:0]   pin_out;
  logic              reset_done;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // 200 MHz interface clock; debounce clock 16x slower, edges never on if posedges
  always #2.5 if_clk = ~if_clk;
  always #40  db_clk = ~db_clk;

  pin_deglitch_filter #(.PINS(PINS), .TIME_W(TIME_W)) uut (
    .if_clk(if_clk), .db_clk(db_clk), .rst_n(rst_n),
    .pin_in(pin_in), .filt_en(filt_en), .dir_in(dir_in),
    .hold_time(hold_time), .pin_out(pin_out), .reset_done(reset_done)
  );

  // Sticky record of every pin that went high at the output
  logic [PINS-1:0] seen = '0;
  logic            seen_clr = 1'b1;
  always @(negedge if_clk) begin
    if (seen_clr) seen <= '0;
    else          seen <= seen | pin_out;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h @%0t", tag, act, exp, $time);
    end
  endtask

  task automatic db_wait(input int n);
    repeat (n) @(negedge db_clk);
  endtask

  task automatic if_wait(input int n);
    repeat (n) @(negedge if_clk);
  endtask

  task automatic clear_seen();
    seen_clr = 1'b1;
    if_wait(2);
    seen_clr = 1'b0;
  endtask

  // Expected acceptance mask when pin i holds high for i+1 periods
  function automatic logic [PINS-1:0] accept_mask(input int t);
    logic [PINS-1:0] m = '0;
    for (int i = 0; i < PINS; i++) m[i] = ((i + 1) >= (t + 1));
    return m;
  endfunction

  initial begin
    rst_n = 1'b0; pin_in = '0; filt_en = '0; dir_in = '1; hold_time = '0;

    // R1: reset state
    db_wait(5);
    chk("R1 pin_out in reset", 32'(pin_out), 32'h0);
    chk("R1 reset_done in reset", 32'(reset_done), 32'h0);

    // R2: done only after the debounce domain is out of reset
    #1.3 rst_n = 1'b1;
    if_wait(3);
    chk("R2 reset_done before debounce release", 32'(reset_done), 32'h0);
    db_wait(4);
    chk("R2 reset_done after both released", 32'(reset_done), 32'h1);

    // R3 and R8: pulse-length sweep across every pin and hold time
    filt_en = '1; dir_in = '1;
    for (int t = 0; t <= 8; t++) begin
      hold_time = TIME_W'(t);
      db_wait(4);
      clear_seen();
      @(negedge db_clk);
      pin_in = '1;
      for (int k = 1; k <= PINS; k++) begin
        db_wait(1);
        pin_in[k-1] = 1'b0;
      end
      db_wait(t + 6);
      chk($sformatf("R3 accepted pulses T=%0d", t), 32'(seen), 32'(accept_mask(t)));
      db_wait(t + 6);
      chk($sformatf("R8 all pins back low T=%0d", t), 32'(pin_out), 32'h0);
    end

    // R4: latency window for a filtered pin
    for (int r = 0; r < 2; r++) begin
      automatic int t = (r == 0) ? 0 : 4;
      hold_time = TIME_W'(t);
      db_wait(4);
      pin_in[0] = 1'b1;
      db_wait(t + 2);
      chk($sformatf("R4 not yet at T+2 T=%0d", t), 32'(pin_out[0]), 32'h0);
      db_wait(1);
      chk($sformatf("R4 present at T+3 T=%0d", t), 32'(pin_out[0]), 32'h1);
      pin_in[0] = 1'b0;
      db_wait(t + 8);
    end

    // R5: an opposite sample in the middle restarts the count
    hold_time = 8'd3;
    db_wait(4);
    clear_seen();
    @(negedge db_clk);
    pin_in[2] = 1'b1; db_wait(3);
    pin_in[2] = 1'b0; db_wait(1);
    pin_in[2] = 1'b1; db_wait(3);
    pin_in[2] = 1'b0; db_wait(10);
    chk("R5 interrupted hold rejected", 32'(seen), 32'h0);
    pin_in[2] = 1'b1; db_wait(4);
    pin_in[2] = 1'b0; db_wait(10);
    chk("R5 unbroken T+1 hold accepted", 32'(seen), 32'h4);
    db_wait(6);

    // R6: filter disabled, bypass timing and a short pulse
    filt_en = '0; dir_in = '1;
    db_wait(4);
    if_wait(1);
    pin_in = 8'h5A;
    if_wait(2);
    chk("R6 bypass before third edge", 32'(pin_out), 32'h0);
    if_wait(1);
    chk("R6 bypass at third edge", 32'(pin_out), 32'h5A);
    pin_in = '0;
    if_wait(6);
    pin_in = 8'h0F;
    if_wait(1);
    pin_in = '0;
    if_wait(2);
    chk("R6 one-cycle pulse passes", 32'(pin_out), 32'h0F);
    if_wait(4);

    // R7: output-direction pins bypass even when enabled
    filt_en = '1; dir_in = '0;
    db_wait(4);
    pin_in = 8'hA5;
    if_wait(3);
    chk("R7 output pin bypasses filter", 32'(pin_out), 32'hA5);
    pin_in = '0;
    dir_in = '1;
    db_wait(8);

    // R1: reset asserted mid-run clears outputs at once
    filt_en = '0;
    pin_in = '1;
    db_wait(2);
    chk("R1 pre-reset bypass high", 32'(pin_out), 32'hFF);
    #1.3 rst_n = 1'b0;
    #1;
    chk("R1 pin_out cleared by reset", 32'(pin_out), 32'h0);
    chk("R1 reset_done cleared by reset", 32'(reset_done), 32'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule